// File: doc/BRIEF.md
# Register and Predicate Remap Table

This block sits beside the instruction decoder. Each register operand it is asked about is identified by a key: a register-file select bit (integer or floating point) and a 5-bit register number. The block compares that key against two small programmable tables at once.

The vector table says whether the operand is to be handled as a vector. If it is, the table gives the physical register where the vector starts and its element width. The predicate table names the register that holds the operand's mask. It also says whether that mask is to be complemented, and whether lanes the mask turns off are to be written as zero instead of being kept.

Software fills either table one entry at a time through a configuration port. It can also drop an entry together with every entry above it. The answer to a query is registered, so it appears one clock after the query is presented.

Top module: `remap_lookup`

## Requirements
- R1: After synchronous reset every entry in both tables is invalid, and `r_valid` is 0.
- R2: A key is the pair {register-file bit, 5-bit number}. An entry matches only when both parts are equal, so integer register 5 and floating-point register 5 are distinct keys.
- R3: When a query hits a valid vector entry, the result shows `r_vector`=1 and carries that entry's start register and width code.
- R4: When a query misses the vector table, the result shows `r_vector`=0, `r_width`=0, `r_width_bad`=0, and `r_start` equal to the queried register number.
- R5: When a query hits a valid predicate entry, the result shows `r_pred`=1 and carries that entry's mask register, invert flag and zeroing flag. On a miss, `r_pred`, `r_pred_reg`, `r_pred_inv` and `r_pred_zero` are all 0. The two tables are looked up independently.
- R6: A query presented with `q_valid`=1 at a rising edge is answered in the outputs right after that edge, with `r_valid`=1. After an edge with `q_valid`=0, `r_valid` is 0 and the other outputs keep their values.
- R7: If several valid entries of one table match, the entry with the lowest index supplies the result.
- R8: Width codes are 0=default, 1=8 bits, 2=16 bits, 3=32 bits and 4=64 bits. Codes 5 to 7 are accepted and stored. A hit on such an entry returns the code with `r_width_bad`=1; a hit on any other code gives `r_width_bad`=0.
- R9: `cfg_clr` with index N (table chosen by `cfg_sel_pred`: 0 = vector, 1 = predicate) invalidates entries N and above of that table only. Lower entries, and the other table, are unchanged.
- R10: `cfg_we` writes entry `cfg_idx` of the chosen table and marks it valid. A query in the same cycle as a write sees the table as it stood before that write.
- R11: When `cfg_clr` and `cfg_we` are both high, the clear is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one entry |
| cfg_clr | input | 1 | Invalidate entry `cfg_idx` and all higher entries |
| cfg_sel_pred | input | 1 | Table select: 0 vector, 1 predicate |
| cfg_idx | input | IDX_W (2) | Entry index |
| cfg_key_fp | input | 1 | Key register-file bit (1 = floating point) |
| cfg_key_num | input | 5 | Key register number |
| cfg_val | input | 5 | Start register (vector) or mask register (predicate) |
| cfg_width | input | 3 | Element width code (vector table) |
| cfg_inv | input | 1 | Mask invert flag (predicate table) |
| cfg_zero | input | 1 | Zero masked-off lanes flag (predicate table) |
| q_valid | input | 1 | Query present |
| q_fp | input | 1 | Query register-file bit |
| q_num | input | 5 | Query register number |
| r_valid | output | 1 | Result corresponds to a query one cycle earlier |
| r_vector | output | 1 | Operand is a vector |
| r_start | output | 5 | Physical start register |
| r_width | output | 3 | Element width code |
| r_width_bad | output | 1 | Stored width code is reserved |
| r_pred | output | 1 | Operand is predicated |
| r_pred_reg | output | 5 | Register holding the mask |
| r_pred_inv | output | 1 | Mask is complemented |
| r_pred_zero | output | 1 | Masked-off lanes are zeroed |

## Verification
Two pairs of functions can land in the same clock. The first pair is a configuration update and a lookup. The bench provokes this by writing an entry while querying its key on the same edge; the result must show a miss, and the next query must show the hit. The second pair is a clear and a write raised together on one table. The outcome is judged only through later queries, which must show the cleared range empty and the written key absent.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int REGNUM_W = 5;
    localparam int WIDTH_W  = 3;

    localparam logic [WIDTH_W-1:0] EW_LAST_LEGAL = 3'd4;

    typedef struct packed {
        logic                is_fp;
        logic [REGNUM_W-1:0] num;
    } rkey_t;

    typedef struct packed {
        logic                valid;
        rkey_t               key;
        logic [REGNUM_W-1:0] start;
        logic [WIDTH_W-1:0]  width;
    } vreg_ent_t;

    typedef struct packed {
        logic                valid;
        rkey_t               key;
        logic [REGNUM_W-1:0] mask_reg;
        logic                inv;
        logic                zero;
    } pred_ent_t;

    typedef struct packed {
        logic                vector;
        logic [REGNUM_W-1:0] start;
        logic [WIDTH_W-1:0]  width;
        logic                width_bad;
        logic                pred;
        logic [REGNUM_W-1:0] pred_reg;
        logic                pred_inv;
        logic                pred_zero;
    } lookup_t;

    function automatic logic width_reserved(input logic [WIDTH_W-1:0] w);
        return w > EW_LAST_LEGAL;
    endfunction

endpackage

// File: rtl/remap_first_hit.sv
module remap_first_hit #(
    parameter int N = 4
) (
    input  logic [N-1:0] hit,
    output logic [N-1:0] grant,
    output logic         found
);
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assign found = |hit;
endmodule

// File: rtl/remap_vreg_store.sv
module remap_vreg_store
    import remap_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic                clr,
    input  logic [IDX_W-1:0]    idx,
    input  rkey_t               wkey,
    input  logic [REGNUM_W-1:0] wstart,
    input  logic [WIDTH_W-1:0]  wwidth,
    input  rkey_t               qkey,
    output logic                hit_o,
    output logic [REGNUM_W-1:0] start_o,
    output logic [WIDTH_W-1:0]  width_o
);
    vreg_ent_t          ent [N];
    logic [N-1:0]       hit_vec;
    logic [N-1:0]       grant;
    logic               idx_ok;

    assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(N));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < N; i++)
                if ((IDX_W+1)'(i) >= {1'b0, idx}) ent[i].valid <= 1'b0;
        end else if (we && idx_ok) begin
            for (int i = 0; i < N; i++)
                if ((IDX_W+1)'(i) == {1'b0, idx})
                    ent[i] <= '{valid: 1'b1, key: wkey, start: wstart, width: wwidth};
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_match
        assign hit_vec[g] = ent[g].valid && (ent[g].key == qkey);

        // R9: a clear at or below this index empties it
        a_r9_vreg_clear: assert property (@(posedge clk) disable iff (rst)
            (clr && ((IDX_W+1)'(g) >= {1'b0, idx})) |=> !ent[g].valid);
        // R10: a lone write makes the entry valid
        a_r10_vreg_write: assert property (@(posedge clk) disable iff (rst)
            (we && !clr && ((IDX_W+1)'(g) == {1'b0, idx})) |=> ent[g].valid);
    end

    remap_first_hit #(.N(N)) u_pick (
        .hit   (hit_vec),
        .grant (grant),
        .found (hit_o)
    );

    always_comb begin
        start_o = '0;
        width_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                start_o |= ent[i].start;
                width_o |= ent[i].width;
            end
        end
    end

    // R7: no lower-indexed match is passed over
    a_r7_vreg_lowest: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((hit_vec & (grant - 1'b1)) == '0));
endmodule

// File: rtl/remap_pred_store.sv
module remap_pred_store
    import remap_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic                clr,
    input  logic [IDX_W-1:0]    idx,
    input  rkey_t               wkey,
    input  logic [REGNUM_W-1:0] wmask,
    input  logic                winv,
    input  logic                wzero,
    input  rkey_t               qkey,
    output logic                hit_o,
    output logic [REGNUM_W-1:0] mask_o,
    output logic                inv_o,
    output logic                zero_o
);
    pred_ent_t          ent [N];
    logic [N-1:0]       hit_vec;
    logic [N-1:0]       grant;
    logic               idx_ok;

    assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(N));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < N; i++)
                if ((IDX_W+1)'(i) >= {1'b0, idx}) ent[i].valid <= 1'b0;
        end else if (we && idx_ok) begin
            for (int i = 0; i < N; i++)
                if ((IDX_W+1)'(i) == {1'b0, idx})
                    ent[i] <= '{valid: 1'b1, key: wkey, mask_reg: wmask,
                                inv: winv, zero: wzero};
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_match
        assign hit_vec[g] = ent[g].valid && (ent[g].key == qkey);

        // R9: a clear at or below this index empties it
        a_r9_pred_clear: assert property (@(posedge clk) disable iff (rst)
            (clr && ((IDX_W+1)'(g) >= {1'b0, idx})) |=> !ent[g].valid);
        // R11: a clear raised with a write keeps entries above it unwritten
        a_r11_pred_clr_wins: assert property (@(posedge clk) disable iff (rst)
            (clr && we && ((IDX_W+1)'(g) == {1'b0, idx})) |=> !ent[g].valid);
    end

    remap_first_hit #(.N(N)) u_pick (
        .hit   (hit_vec),
        .grant (grant),
        .found (hit_o)
    );

    always_comb begin
        mask_o = '0;
        inv_o  = 1'b0;
        zero_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                mask_o |= ent[i].mask_reg;
                inv_o  |= ent[i].inv;
                zero_o |= ent[i].zero;
            end
        end
    end

    // R7: no lower-indexed match is passed over
    a_r7_pred_lowest: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((hit_vec & (grant - 1'b1)) == '0));
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
    import remap_pkg::*;
#(
    parameter int VREG_ENTRIES = 4,
    parameter int PRED_ENTRIES = 4,
    localparam int MAX_ENTRIES = (VREG_ENTRIES > PRED_ENTRIES) ? VREG_ENTRIES : PRED_ENTRIES,
    localparam int IDX_W       = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic                cfg_clr,
    input  logic                cfg_sel_pred,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic                cfg_key_fp,
    input  logic [REGNUM_W-1:0] cfg_key_num,
    input  logic [REGNUM_W-1:0] cfg_val,
    input  logic [WIDTH_W-1:0]  cfg_width,
    input  logic                cfg_inv,
    input  logic                cfg_zero,
    input  logic                q_valid,
    input  logic                q_fp,
    input  logic [REGNUM_W-1:0] q_num,
    output logic                r_valid,
    output logic                r_vector,
    output logic [REGNUM_W-1:0] r_start,
    output logic [WIDTH_W-1:0]  r_width,
    output logic                r_width_bad,
    output logic                r_pred,
    output logic [REGNUM_W-1:0] r_pred_reg,
    output logic                r_pred_inv,
    output logic                r_pred_zero
);
    rkey_t               wkey, qkey;
    logic                v_hit, p_hit;
    logic [REGNUM_W-1:0] v_start, p_mask;
    logic [WIDTH_W-1:0]  v_width;
    logic                p_inv, p_zero;
    lookup_t             nxt, res_q;
    logic                valid_q;

    assign wkey = '{is_fp: cfg_key_fp, num: cfg_key_num};
    assign qkey = '{is_fp: q_fp, num: q_num};

    remap_vreg_store #(.N(VREG_ENTRIES), .IDX_W(IDX_W)) u_vreg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we && !cfg_sel_pred),
        .clr     (cfg_clr && !cfg_sel_pred),
        .idx     (cfg_idx),
        .wkey    (wkey),
        .wstart  (cfg_val),
        .wwidth  (cfg_width),
        .qkey    (qkey),
        .hit_o   (v_hit),
        .start_o (v_start),
        .width_o (v_width)
    );

    remap_pred_store #(.N(PRED_ENTRIES), .IDX_W(IDX_W)) u_pred (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we && cfg_sel_pred),
        .clr    (cfg_clr && cfg_sel_pred),
        .idx    (cfg_idx),
        .wkey   (wkey),
        .wmask  (cfg_val),
        .winv   (cfg_inv),
        .wzero  (cfg_zero),
        .qkey   (qkey),
        .hit_o  (p_hit),
        .mask_o (p_mask),
        .inv_o  (p_inv),
        .zero_o (p_zero)
    );

    always_comb begin
        nxt       = '0;
        nxt.start = q_num;
        if (v_hit) begin
            nxt.vector    = 1'b1;
            nxt.start     = v_start;
            nxt.width     = v_width;
            nxt.width_bad = width_reserved(v_width);
        end
        if (p_hit) begin
            nxt.pred      = 1'b1;
            nxt.pred_reg  = p_mask;
            nxt.pred_inv  = p_inv;
            nxt.pred_zero = p_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= q_valid;
            if (q_valid) res_q <= nxt;
        end
    end

    assign r_valid     = valid_q;
    assign r_vector    = res_q.vector;
    assign r_start     = res_q.start;
    assign r_width     = res_q.width;
    assign r_width_bad = res_q.width_bad;
    assign r_pred      = res_q.pred;
    assign r_pred_reg  = res_q.pred_reg;
    assign r_pred_inv  = res_q.pred_inv;
    assign r_pred_zero = res_q.pred_zero;

    // R6: one-cycle answer
    a_r6_answer: assert property (@(posedge clk) disable iff (rst)
        q_valid |=> r_valid);
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        !q_valid |=> (!r_valid && $stable(r_start) && $stable(r_pred)));
    // R4: a vector miss passes the register number through
    a_r4_miss_start: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !v_hit) |=> (!r_vector && r_start == $past(q_num) && r_width == '0));
    // R8: a reserved-width flag only accompanies a vector hit
    a_r8_bad_needs_vec: assert property (@(posedge clk) disable iff (rst)
        r_width_bad |-> r_vector);
    // R5: predicate attributes are zero without a predicate hit
    a_r5_flags_need_pred: assert property (@(posedge clk) disable iff (rst)
        !r_pred |-> (!r_pred_inv && !r_pred_zero && r_pred_reg == '0));
endmodule

// File: tb/tb_remap_lookup.sv
module tb_remap_lookup;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we, cfg_clr, cfg_sel_pred;
    logic [1:0] cfg_idx;
    logic       cfg_key_fp;
    logic [4:0] cfg_key_num, cfg_val;
    logic [2:0] cfg_width;
    logic       cfg_inv, cfg_zero;
    logic       q_valid, q_fp;
    logic [4:0] q_num;
    logic       r_valid, r_vector, r_width_bad, r_pred, r_pred_inv, r_pred_zero;
    logic [4:0] r_start, r_pred_reg;
    logic [2:0] r_width;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    remap_lookup dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_clr(cfg_clr), .cfg_sel_pred(cfg_sel_pred),
        .cfg_idx(cfg_idx), .cfg_key_fp(cfg_key_fp), .cfg_key_num(cfg_key_num),
        .cfg_val(cfg_val), .cfg_width(cfg_width), .cfg_inv(cfg_inv), .cfg_zero(cfg_zero),
        .q_valid(q_valid), .q_fp(q_fp), .q_num(q_num),
        .r_valid(r_valid), .r_vector(r_vector), .r_start(r_start), .r_width(r_width),
        .r_width_bad(r_width_bad), .r_pred(r_pred), .r_pred_reg(r_pred_reg),
        .r_pred_inv(r_pred_inv), .r_pred_zero(r_pred_zero)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_clr = 0; cfg_sel_pred = 0; cfg_idx = 0;
        cfg_key_fp = 0; cfg_key_num = 0; cfg_val = 0; cfg_width = 0;
        cfg_inv = 0; cfg_zero = 0; q_valid = 0; q_fp = 0; q_num = 0;
    endtask

    task automatic set_cfg(input logic sel, input logic [1:0] idx, input logic fp,
                           input logic [4:0] num, input logic [4:0] val,
                           input logic [2:0] w, input logic inv, input logic zero);
        cfg_sel_pred = sel; cfg_idx = idx; cfg_key_fp = fp; cfg_key_num = num;
        cfg_val = val; cfg_width = w; cfg_inv = inv; cfg_zero = zero;
    endtask

    task automatic write_ent(input logic sel, input logic [1:0] idx, input logic fp,
                             input logic [4:0] num, input logic [4:0] val,
                             input logic [2:0] w, input logic inv, input logic zero);
        @(negedge clk);
        set_cfg(sel, idx, fp, num, val, w, inv, zero);
        cfg_we = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic clear_from(input logic sel, input logic [1:0] idx);
        @(negedge clk);
        cfg_sel_pred = sel; cfg_idx = idx; cfg_clr = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    // query is applied for one edge; outputs are read at the following falling edge
    task automatic query(input logic fp, input logic [4:0] num);
        @(negedge clk);
        q_valid = 1; q_fp = fp; q_num = num;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic expect_vec(input string tag, input int vec, input int start, input int w, input int bad);
        check({tag, " r_valid"}, int'(r_valid), 1);
        check({tag, " r_vector"}, int'(r_vector), vec);
        check({tag, " r_start"}, int'(r_start), start);
        check({tag, " r_width"}, int'(r_width), w);
        check({tag, " r_width_bad"}, int'(r_width_bad), bad);
    endtask

    task automatic expect_pred(input string tag, input int p, input int reg_n, input int inv, input int zero);
        check({tag, " r_pred"}, int'(r_pred), p);
        check({tag, " r_pred_reg"}, int'(r_pred_reg), reg_n);
        check({tag, " r_pred_inv"}, int'(r_pred_inv), inv);
        check({tag, " r_pred_zero"}, int'(r_pred_zero), zero);
    endtask

    task automatic t_reset();
        check("R1 r_valid after reset", int'(r_valid), 0);
        query(1'b0, 5'd3);
        expect_vec("R1/R4 empty table", 0, 3, 0, 0);
        expect_pred("R1/R5 empty table", 0, 0, 0, 0);
    endtask

    task automatic t_vector_hit();
        write_ent(1'b0, 2'd0, 1'b0, 5'd5, 5'd20, 3'd3, 1'b0, 1'b0);
        query(1'b0, 5'd5);
        expect_vec("R3 int5 hit", 1, 20, 3, 0);
        query(1'b1, 5'd5);
        expect_vec("R2 fp5 distinct key", 0, 5, 0, 0);
    endtask

    task automatic t_pred_hit();
        write_ent(1'b1, 2'd0, 1'b0, 5'd5, 5'd7, 3'd0, 1'b1, 1'b0);
        write_ent(1'b1, 2'd1, 1'b1, 5'd2, 5'd9, 3'd0, 1'b0, 1'b1);
        query(1'b0, 5'd5);
        expect_pred("R5 int5 pred", 1, 7, 1, 0);
        expect_vec("R5 vec alongside pred", 1, 20, 3, 0);
        query(1'b1, 5'd2);
        expect_pred("R5 fp2 pred zeroing", 1, 9, 0, 1);
        expect_vec("R5 fp2 no vector", 0, 2, 0, 0);
        query(1'b0, 5'd6);
        expect_pred("R5 int6 miss", 0, 0, 0, 0);
    endtask

    task automatic t_priority();
        write_ent(1'b0, 2'd2, 1'b0, 5'd9, 5'd11, 3'd1, 1'b0, 1'b0);
        write_ent(1'b0, 2'd1, 1'b0, 5'd9, 5'd12, 3'd2, 1'b0, 1'b0);
        query(1'b0, 5'd9);
        expect_vec("R7 lowest index wins", 1, 12, 2, 0);
    endtask

    task automatic t_widths();
        write_ent(1'b0, 2'd3, 1'b1, 5'd1, 5'd2, 3'd6, 1'b0, 1'b0);
        query(1'b1, 5'd1);
        expect_vec("R8 reserved width", 1, 2, 6, 1);
        write_ent(1'b0, 2'd3, 1'b1, 5'd1, 5'd4, 3'd4, 1'b0, 1'b0);
        query(1'b1, 5'd1);
        expect_vec("R8 width 64", 1, 4, 4, 0);
    endtask

    task automatic t_clear();
        clear_from(1'b0, 2'd1);
        query(1'b0, 5'd5);
        expect_vec("R9 entry below kept", 1, 20, 3, 0);
        expect_pred("R9 other table kept", 1, 7, 1, 0);
        query(1'b0, 5'd9);
        expect_vec("R9 entries 1-2 gone", 0, 9, 0, 0);
        query(1'b1, 5'd1);
        expect_vec("R9 entry 3 gone", 0, 1, 0, 0);
        clear_from(1'b1, 2'd1);
        query(1'b1, 5'd2);
        expect_pred("R9 pred entry1 gone", 0, 0, 0, 0);
        query(1'b0, 5'd5);
        expect_pred("R9 pred entry0 kept", 1, 7, 1, 0);
    endtask

    task automatic t_write_and_query();
        @(negedge clk);
        set_cfg(1'b0, 2'd1, 1'b0, 5'd12, 5'd30, 3'd2, 1'b0, 1'b0);
        cfg_we = 1;
        q_valid = 1; q_fp = 0; q_num = 5'd12;
        @(negedge clk);
        idle_inputs();
        expect_vec("R10 same-cycle query sees old", 0, 12, 0, 0);
        query(1'b0, 5'd12);
        expect_vec("R10 next query sees write", 1, 30, 2, 0);
    endtask

    task automatic t_clear_beats_write();
        @(negedge clk);
        set_cfg(1'b0, 2'd1, 1'b1, 5'd7, 5'd3, 3'd1, 1'b0, 1'b0);
        cfg_we = 1; cfg_clr = 1;
        @(negedge clk);
        idle_inputs();
        query(1'b1, 5'd7);
        expect_vec("R11 write dropped", 0, 7, 0, 0);
        query(1'b0, 5'd12);
        expect_vec("R11 clear performed", 0, 12, 0, 0);
        query(1'b0, 5'd5);
        expect_vec("R11 entry0 kept", 1, 20, 3, 0);
    endtask

    task automatic t_idle_hold();
        query(1'b0, 5'd5);
        @(negedge clk);
        check("R6 r_valid drops when idle", int'(r_valid), 0);
        check("R6 r_start held", int'(r_start), 20);
        check("R6 r_pred_reg held", int'(r_pred_reg), 7);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_vector_hit();
        t_pred_hit();
        t_priority();
        t_widths();
        t_clear();
        t_write_and_query();
        t_clear_beats_write();
        t_idle_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule